// File: doc/BRIEF.md
# Two-Wire Start Pattern Classifier

This block monitors a self-clocked two-wire peripheral bus in which lines A and B take turns carrying clock and data. Before any bytes move, the transmitter sends a control pattern. Line A is pulled low while line B is high. Line B is then toggled a number of times. The pattern ends when line A rises again. The number of line-B falling edges inside that window sets the pattern type.

Both line levels are sampled by a much faster system clock through a two-flop synchroniser. Edges are found by comparing each synchronised sample with the one before it. When line A rises, the block issues exactly one single-cycle pulse. That pulse marks a normal start, a start with CRC, a bus occupancy pattern, a bus reset pattern or a frame error.

Both start types raise a frame-open flag that hands the bus to a downstream byte receiver. That receiver ends the frame with a one-cycle done strobe. While a frame is open, the classifier ignores all line activity.

Top module: `tw_start_classifier`

## Requirements
- R1: After reset all pulse outputs are low and `frame_open_o` is low.
- R2: The block arms only when the synchronised line A is low and line B is high at the same time. Line-B falling edges seen while it is not armed are not counted.
- R3: Exactly 4 line-B falling edges while armed, followed by line A rising with line B high, give one `start_o` pulse and set `frame_open_o`.
- R4: Exactly 6 such edges give one `start_crc_o` pulse and set `frame_open_o`.
- R5: Exactly 8 such edges give one `occupancy_o` pulse, and `frame_open_o` stays low.
- R6: 14 or more such edges give one `reset_pat_o` pulse, and `frame_open_o` stays low. The edge counter saturates at 15, so a very long pattern (for example 40 edges) still counts as a reset.
- R7: Any other count, such as 0, 5, 9 or 13, gives one `frame_err_o` pulse and leaves `frame_open_o` low.
- R8: If line B is low when line A rises, the result is a `frame_err_o` pulse whatever the count.
- R9: No more than one of the five pulse outputs is high in any cycle, and each pulse lasts exactly one cycle.
- R10: While `frame_open_o` is high, line activity produces no pulses. A high `frame_done_i` clears `frame_open_o`, and the block can then arm again.
- R11: After a frame error the block re-arms, and the next pattern is classified normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_a_i | input | 1 | Bus line A level (asynchronous) |
| line_b_i | input | 1 | Bus line B level (asynchronous) |
| frame_done_i | input | 1 | Byte receiver has finished the frame |
| start_o | output | 1 | Normal start pulse |
| start_crc_o | output | 1 | Start-with-CRC pulse |
| occupancy_o | output | 1 | Bus occupancy pattern pulse |
| reset_pat_o | output | 1 | Bus reset pattern pulse |
| frame_err_o | output | 1 | Malformed pattern pulse |
| frame_open_o | output | 1 | Frame in progress, byte receiver enabled |

## Verification
Patterns with 4, 6, 8, 14 and 40 falling edges each exercise one class. The 40-edge case shows whether the counter saturates or wraps, since a wrapped count would look like an occupancy pattern. Counts of 0, 5, 9 and 13 sit next to the valid values and must all be rejected. A 4-edge pattern that ends with line B low separates the line-B check from the count check. Line-B toggles made before arming, and patterns sent while a frame is open, show that edges are counted only inside the armed window.

// File: rtl/tw_start_pkg.sv
package tw_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_OPEN  = 2'd2
  } tw_state_e;

  typedef struct packed {
    logic start;
    logic start_crc;
    logic occupancy;
    logic reset_pat;
    logic frame_err;
  } tw_pulse_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tw_edge_cnt.sv
module tw_edge_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i && cnt_o != CntMax) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tw_start_classifier.sv
module tw_start_classifier
  import tw_start_pkg::*;
#(
  parameter int unsigned START_CNT = 4,
  parameter int unsigned CRC_CNT   = 6,
  parameter int unsigned OCC_CNT   = 8,
  parameter int unsigned RST_MIN   = 14,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_a_i,
  input  logic line_b_i,
  input  logic frame_done_i,
  output logic start_o,
  output logic start_crc_o,
  output logic occupancy_o,
  output logic reset_pat_o,
  output logic frame_err_o,
  output logic frame_open_o
);
  localparam int unsigned CntW = $clog2(RST_MIN + 2);

  logic [1:0]      lines_s;
  logic            a_s, b_s, a_q, b_q;
  logic            rise_a, fall_b, arm;
  logic [CntW-1:0] cnt;
  tw_state_e       state_q, state_d;
  tw_pulse_t       pulse_d, pulse_q;

  tw_sync #(.WIDTH(2), .STAGES(SYNC_STG), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({line_a_i, line_b_i}),
    .q_o   (lines_s)
  );
  assign a_s = lines_s[1];
  assign b_s = lines_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
    end else begin
      a_q <= a_s;
      b_q <= b_s;
    end
  end

  assign rise_a = a_s & ~a_q;
  assign fall_b = b_q & ~b_s;
  assign arm    = (state_q == ST_IDLE) && !a_s && b_s;

  tw_edge_cnt #(.CNT_W(CntW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (arm),
    .inc_i ((state_q == ST_ARMED) && fall_b && !rise_a),
    .cnt_o (cnt)
  );

  always_comb begin
    state_d = state_q;
    pulse_d = '0;
    unique case (state_q)
      ST_IDLE:  if (arm) state_d = ST_ARMED;
      ST_ARMED: begin
        if (rise_a) begin
          state_d = ST_IDLE;
          if (!b_s)                              pulse_d.frame_err = 1'b1;
          else if (cnt == CntW'(START_CNT))      begin pulse_d.start     = 1'b1; state_d = ST_OPEN; end
          else if (cnt == CntW'(CRC_CNT))        begin pulse_d.start_crc = 1'b1; state_d = ST_OPEN; end
          else if (cnt == CntW'(OCC_CNT))        pulse_d.occupancy = 1'b1;
          else if (cnt >= CntW'(RST_MIN))        pulse_d.reset_pat = 1'b1;
          else                                   pulse_d.frame_err = 1'b1;
        end
      end
      ST_OPEN:  if (frame_done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign start_o      = pulse_q.start;
  assign start_crc_o  = pulse_q.start_crc;
  assign occupancy_o  = pulse_q.occupancy;
  assign reset_pat_o  = pulse_q.reset_pat;
  assign frame_err_o  = pulse_q.frame_err;
  assign frame_open_o = (state_q == ST_OPEN);
endmodule

// File: rtl/tw_start_classifier_chk.sv
module tw_start_classifier_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic line_a_i,
  input logic line_b_i,
  input logic frame_done_i,
  input logic start_o,
  input logic start_crc_o,
  input logic occupancy_o,
  input logic reset_pat_o,
  input logic frame_err_o,
  input logic frame_open_o
);
  assert_one_class_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, start_crc_o, occupancy_o, reset_pat_o, frame_err_o}));

  assert_start_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_err_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);

  assert_open_from_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_open_o) |-> (start_o || start_crc_o));

  assert_occ_closed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occupancy_o |-> !frame_open_o);

  assert_rst_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_pat_o |-> !frame_open_o);

  assert_open_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_open_o && !frame_done_i) |=> (frame_open_o && !occupancy_o && !reset_pat_o && !frame_err_o));

  assert_done_closes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_open_o && frame_done_i) |=> !frame_open_o);
endmodule

bind tw_start_classifier tw_start_classifier_chk chk_i (.*);

// File: tb/tw_start_classifier_tb.sv
module tw_start_classifier_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line_a = 1'b1, line_b = 1'b1, frame_done = 1'b0;
  logic start, start_crc, occupancy, reset_pat, frame_err, frame_open;

  int n_chk = 0, n_err = 0, cyc = 0;
  int c_s = 0, c_c = 0, c_o = 0, c_r = 0, c_e = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tw_start_classifier dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .line_a_i(line_a), .line_b_i(line_b),
    .frame_done_i(frame_done), .start_o(start), .start_crc_o(start_crc),
    .occupancy_o(occupancy), .reset_pat_o(reset_pat), .frame_err_o(frame_err),
    .frame_open_o(frame_open)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_ni) begin
      c_s <= c_s + int'(start);
      c_c <= c_c + int'(start_crc);
      c_o <= c_o + int'(occupancy);
      c_r <= c_r + int'(reset_pat);
      c_e <= c_e + int'(frame_err);
    end
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // pattern: A low with B high, n falls of B, A rises (B high if b_hi)
  task automatic send(int n, bit b_hi);
    line_a = 1'b0; line_b = 1'b1; wait_cyc(5);
    for (int i = 0; i < n; i++) begin
      line_b = 1'b0; wait_cyc(3);
      line_b = 1'b1; wait_cyc(3);
    end
    if (!b_hi) begin line_b = 1'b0; wait_cyc(3); end
    line_a = 1'b1; wait_cyc(8);
    line_b = 1'b1; wait_cyc(5);
  endtask

  task automatic run_case(string r, int n, bit b_hi, int es, int ec, int eo, int er, int ee, int eopen);
    int s0 = c_s, c0 = c_c, o0 = c_o, r0 = c_r, e0 = c_e;
    send(n, b_hi);
    chk({r, " start"},     c_s - s0, es);
    chk({r, " start_crc"}, c_c - c0, ec);
    chk({r, " occupancy"}, c_o - o0, eo);
    chk({r, " reset_pat"}, c_r - r0, er);
    chk({r, " frame_err"}, c_e - e0, ee);
    chk({r, " frame_open"}, int'(frame_open), eopen);
  endtask

  task automatic close_frame();
    frame_done = 1'b1; wait_cyc(1);
    frame_done = 1'b0; wait_cyc(2);
    chk("R10 closed by done", int'(frame_open), 0);
  endtask

  task automatic t_reset();
    chk("R1 pulses", int'({start, start_crc, occupancy, reset_pat, frame_err}), 0);
    chk("R1 frame_open", int'(frame_open), 0);
  endtask

  task automatic t_classes();
    run_case("R3", 4, 1, 1, 0, 0, 0, 0, 1); close_frame();
    run_case("R4", 6, 1, 0, 1, 0, 0, 0, 1); close_frame();
    run_case("R5", 8, 1, 0, 0, 1, 0, 0, 0);
    run_case("R6 n14", 14, 1, 0, 0, 0, 1, 0, 0);
    run_case("R6 n40 sat", 40, 1, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_errors();
    run_case("R7 n0", 0, 1, 0, 0, 0, 0, 1, 0);
    run_case("R7 n5", 5, 1, 0, 0, 0, 0, 1, 0);
    run_case("R7 n9", 9, 1, 0, 0, 0, 0, 1, 0);
    run_case("R7 n13", 13, 1, 0, 0, 0, 0, 1, 0);
    run_case("R8 b low", 4, 0, 0, 0, 0, 0, 1, 0);
    run_case("R11 after err", 6, 1, 0, 1, 0, 0, 0, 1); close_frame();
  endtask

  task automatic t_arming();
    int s0;
    // B toggles while A high: not armed, not counted
    for (int i = 0; i < 3; i++) begin
      line_b = 1'b0; wait_cyc(3); line_b = 1'b1; wait_cyc(3);
    end
    run_case("R2 pre toggles", 4, 1, 1, 0, 0, 0, 0, 1); close_frame();
    // A falls while B low: arming only once B rises
    s0 = c_s;
    line_b = 1'b0; wait_cyc(3);
    line_a = 1'b0; wait_cyc(3);
    line_b = 1'b1; wait_cyc(5);
    for (int i = 0; i < 4; i++) begin
      line_b = 1'b0; wait_cyc(3); line_b = 1'b1; wait_cyc(3);
    end
    line_a = 1'b1; wait_cyc(8);
    chk("R2 late arm start", c_s - s0, 1);
    chk("R2 late arm open", int'(frame_open), 1);
    close_frame();
  endtask

  task automatic t_open_quiet();
    int s0;
    run_case("R10 open", 4, 1, 1, 0, 0, 0, 0, 1);
    s0 = c_s + c_c + c_o + c_r + c_e;
    send(8, 1);
    send(3, 1);
    chk("R10 ignored pulses", c_s + c_c + c_o + c_r + c_e - s0, 0);
    chk("R10 still open", int'(frame_open), 1);
    close_frame();
    run_case("R10 rearm", 8, 1, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    wait_cyc(4);
    t_reset();
    rst_ni = 1'b1;
    wait_cyc(6);
    t_reset();
    t_classes();
    t_errors();
    t_arming();
    t_open_quiet();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule